// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

This block is a general-purpose I/O port of up to 32 pins behind a 32-bit word-addressed register bus. Software sets each pin's direction and output level. It can use whole-word writes, or set and clear aliases that touch only the bits marked in the written mask. Each pin also has its own configuration word with three fields: direction, input-buffer disconnect and pull selection. The direction bit in that word and the pin's bit in the direction word are one and the same storage, so a write through either path shows up in both.

On the pad side, each pin has a level input and a "driven" flag. A pin whose driven flag is low is floating. The port resolves a pad value per pin in the following order of priority:
- its own output when the pin is an output,
- otherwise the external level when the pin is driven,
- otherwise the selected pull,
- otherwise the last resolved value.

The input word shows that value for every pin whose input buffer is connected. If the port drives a pin while an outside source drives the opposite level, the port raises a sticky error flag that only reset clears.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction word reads 0, the output word reads 0, every pin configuration word reads 0x00000002, pin_oe is all zero and conflict_err is 0.
- R2: A write to the direction-set alias sets exactly the masked direction bits, and a write to the direction-clear alias clears them. Bit 0 of each affected pin's configuration word follows, and so does pin_oe.
- R3: A whole-word write to the direction register updates bit 0 of every pin's configuration word. A write to one pin's configuration word sets that pin's direction bit from bit 0 of the written data.
- R4: The output word, output-set alias and output-clear alias control pin_out in the same way as the direction aliases. pin_oe equals the direction bits.
- R5: With configuration 0 (input, buffer connected) and the pin driven, the pin's input bit equals pin_level one clock after the level is applied.
- R6: With the buffer connected, no pull and the pin undriven, the input bit keeps its previous resolved value.
- R7: With the pin undriven, pull field (configuration bits 3:2) 2'b11 reads the input bit as 1 and 2'b01 reads it as 0.
- R8: With configuration bit 1 set (input buffer disconnected), the pin's input bit reads 0 whatever the pad does.
- R9: With the pin configured as output (configuration bit 0 = 1, buffer connected), the input bit reads back the value on pin_out.
- R10: conflict_err sets in the cycle after a pin has pin_oe high, pin_driven high and pin_level different from pin_out. It then stays set until reset. An input pin driven externally never sets it.
- R11: Writes to the input word change nothing. Configuration bits above bit 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pin_level | input | NPINS | Level an outside source puts on each pin |
| pin_driven | input | NPINS | High where an outside source drives the pin |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin (the direction bits) |
| conflict_err | output | 1 | Sticky flag for output/external drive conflict |

## Verification
If the shared direction storage goes wrong, it shows at once on pin_oe and in the configuration readback of the pin concerned, in the cycle after the write. If the pad resolution goes wrong, for example a wrong pull polarity, a lost hold value or a missing loopback, the input word shows a wrong bit one clock after the pad or configuration change. If the error flag does not stay set, or sets for an input pin, conflict_err shows it on the next edge. The tests therefore read each word back right after the write or pad change that should affect it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_RSVD = 2'b10,
        PULL_UP   = 2'b11
    } pull_e;

    typedef struct packed {
        pull_e pull;
        logic  disc;
    } pin_cfg_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_OUTSET,
        SEL_OUTCLR,
        SEL_IN,
        SEL_DIR,
        SEL_DIRSET,
        SEL_DIRCLR,
        SEL_CNF
    } reg_sel_e;

    localparam pin_cfg_t CFG_RESET = '{pull: PULL_NONE, disc: 1'b1};

    // Priority: own drive, external drive, pull, held value.
    function automatic logic resolve_pad(logic dir, logic out, logic drv,
                                         logic lvl, pull_e pull, logic prev);
        logic r;
        if (dir)                  r = out;
        else if (drv)             r = lvl;
        else if (pull == PULL_UP) r = 1'b1;
        else if (pull == PULL_DOWN) r = 1'b0;
        else                      r = prev;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] cnf_word(logic dir, pin_cfg_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[0]   = dir;
        w[1]   = c.disc;
        w[3:2] = c.pull;
        return w;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int ADDR_W     = 7,
    parameter int OFS_OUT    = 1,
    parameter int OFS_OUTSET = 2,
    parameter int OFS_OUTCLR = 3,
    parameter int OFS_IN     = 4,
    parameter int OFS_DIR    = 5,
    parameter int OFS_DIRSET = 6,
    parameter int OFS_DIRCLR = 7,
    parameter int CNF_BASE   = 32,
    localparam int IDX_W     = $clog2(NPINS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] off;
    logic              in_cnf;

    assign off    = addr - ADDR_W'(CNF_BASE);
    assign idx    = off[IDX_W-1:0];
    assign in_cnf = ({1'b0, addr} >= (ADDR_W+1)'(CNF_BASE)) &&
                    ({1'b0, addr} <  (ADDR_W+1)'(CNF_BASE + NPINS));

    always_comb begin
        if (in_cnf)                          sel = SEL_CNF;
        else if (addr == ADDR_W'(OFS_OUT))    sel = SEL_OUT;
        else if (addr == ADDR_W'(OFS_OUTSET)) sel = SEL_OUTSET;
        else if (addr == ADDR_W'(OFS_OUTCLR)) sel = SEL_OUTCLR;
        else if (addr == ADDR_W'(OFS_IN))     sel = SEL_IN;
        else if (addr == ADDR_W'(OFS_DIR))    sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_DIRSET)) sel = SEL_DIRSET;
        else if (addr == ADDR_W'(OFS_DIRCLR)) sel = SEL_DIRCLR;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output pin_cfg_t          cfg_q [NPINS]
);
    logic [NPINS-1:0] mask;
    assign mask = wdata[NPINS-1:0];

    // One copy of direction; the configuration word's bit 0 is a view of it.
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:    dir_q <= mask;
                SEL_DIRSET: dir_q <= dir_q | mask;
                SEL_DIRCLR: dir_q <= dir_q & ~mask;
                SEL_CNF:    dir_q[idx] <= wdata[0];
                default:    dir_q <= dir_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_OUT:    out_q <= mask;
                SEL_OUTSET: out_q <= out_q | mask;
                SEL_OUTCLR: out_q <= out_q & ~mask;
                default:    out_q <= out_q;
            endcase
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= CFG_RESET;
            else if (wr_en && sel == SEL_CNF && idx == IDX_W'(i))
                cfg_q[i] <= '{pull: pull_e'(wdata[3:2]), disc: wdata[1]};
        end
    end
endmodule

// File: rtl/gpio_pad_resolve.sv
module gpio_pad_resolve
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] out_q,
    input  pin_cfg_t         cfg_q [NPINS],
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] pin_driven,
    output logic [NPINS-1:0] in_word,
    output logic             err_q
);
    logic [NPINS-1:0] pad_q;
    logic [NPINS-1:0] clash;

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        always_ff @(posedge clk) begin
            if (rst)
                pad_q[i] <= 1'b0;
            else
                pad_q[i] <= resolve_pad(dir_q[i], out_q[i], pin_driven[i],
                                        pin_level[i], cfg_q[i].pull, pad_q[i]);
        end
        assign in_word[i] = pad_q[i] & ~cfg_q[i].disc;
        assign clash[i]   = dir_q[i] & pin_driven[i] & (pin_level[i] ^ out_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (|clash)  err_q <= 1'b1;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int ADDR_W     = 7,
    parameter int OFS_OUT    = 1,
    parameter int OFS_OUTSET = 2,
    parameter int OFS_OUTCLR = 3,
    parameter int OFS_IN     = 4,
    parameter int OFS_DIR    = 5,
    parameter int OFS_DIRSET = 6,
    parameter int OFS_DIRCLR = 7,
    parameter int CNF_BASE   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pin_level,
    input  logic [NPINS-1:0]  pin_driven,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              conflict_err
);
    localparam int IDX_W = $clog2(NPINS);

    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic [NPINS-1:0] dir_q, out_q, in_word;
    pin_cfg_t         cfg_q [NPINS];

    gpio_addr_dec #(
        .NPINS(NPINS), .ADDR_W(ADDR_W), .OFS_OUT(OFS_OUT),
        .OFS_OUTSET(OFS_OUTSET), .OFS_OUTCLR(OFS_OUTCLR), .OFS_IN(OFS_IN),
        .OFS_DIR(OFS_DIR), .OFS_DIRSET(OFS_DIRSET), .OFS_DIRCLR(OFS_DIRCLR),
        .CNF_BASE(CNF_BASE)
    ) u_dec (
        .addr(addr), .sel(sel), .idx(idx)
    );

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .idx(idx),
        .wdata(wdata), .dir_q(dir_q), .out_q(out_q), .cfg_q(cfg_q)
    );

    gpio_pad_resolve #(.NPINS(NPINS)) u_pad (
        .clk(clk), .rst(rst), .dir_q(dir_q), .out_q(out_q), .cfg_q(cfg_q),
        .pin_level(pin_level), .pin_driven(pin_driven),
        .in_word(in_word), .err_q(conflict_err)
    );

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_OUT, SEL_OUTSET, SEL_OUTCLR: rdata[NPINS-1:0] = out_q;
            SEL_DIR, SEL_DIRSET, SEL_DIRCLR: rdata[NPINS-1:0] = dir_q;
            SEL_IN:                          rdata[NPINS-1:0] = in_word;
            SEL_CNF:                         rdata = cnf_word(dir_q[idx], cfg_q[idx]);
            default:                         rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NPINS      = 32,
    parameter int ADDR_W     = 7,
    parameter int OFS_OUTCLR = 3,
    parameter int OFS_IN     = 4,
    parameter int OFS_DIR    = 5,
    parameter int OFS_DIRSET = 6,
    parameter int OFS_DIRCLR = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [NPINS-1:0]  pin_level,
    input logic [NPINS-1:0]  pin_driven,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              conflict_err
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && !conflict_err));

    // R2
    dirset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_DIRSET)) |=>
        ((pin_oe & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

    // R2
    dirclr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_DIRCLR)) |=>
        ((pin_oe & $past(wdata[NPINS-1:0])) == '0));

    // R3
    dir_word_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_DIR)) |=>
        (pin_oe == $past(wdata[NPINS-1:0])));

    // R4
    outclr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_OUTCLR)) |=>
        ((pin_out & $past(wdata[NPINS-1:0])) == '0));

    // R11
    in_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_IN)) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        conflict_err |=> conflict_err);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(conflict_err) |->
        $past(|(pin_oe & pin_driven & (pin_level ^ pin_out))));
endmodule

bind gpio_port gpio_port_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .OFS_OUTCLR(OFS_OUTCLR), .OFS_IN(OFS_IN),
    .OFS_DIR(OFS_DIR), .OFS_DIRSET(OFS_DIRSET), .OFS_DIRCLR(OFS_DIRCLR)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pin_level(pin_level), .pin_driven(pin_driven), .pin_out(pin_out),
    .pin_oe(pin_oe), .conflict_err(conflict_err)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    localparam int N = 32;
    localparam int AW = 7;
    localparam int A_OUT = 1, A_OUTSET = 2, A_OUTCLR = 3, A_IN = 4;
    localparam int A_DIR = 5, A_DIRSET = 6, A_DIRCLR = 7, A_CNF = 32;
    localparam int TP = 5;  // pin used by the vector table

    // {cnf[3:0], driven, level, out, expected IN bit}
    localparam logic [7:0] VEC [11] = '{
        8'h0D,  // R5 driven high
        8'h08,  // R5 driven low
        8'h0D,  // R5 driven high
        8'h01,  // R6 released, holds 1
        8'hC1,  // R7 pull-up
        8'h40,  // R7 pull-down
        8'h00,  // R6 released, holds 0
        8'h2C,  // R8 disconnected
        8'h13,  // R9 loopback high
        8'h10,  // R9 loopback low
        8'hC1   // R7 pull-up again
    };

    logic clk = 0, rst = 1, wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [N-1:0] pin_level = '0, pin_driven = '0, pin_out, pin_oe;
    logic conflict_err;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_level(pin_level), .pin_driven(pin_driven),
        .pin_out(pin_out), .pin_oe(pin_oe), .conflict_err(conflict_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        addr = AW'(a);
        #1;
        d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        string tag;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(A_DIR, v);   check("R1 DIR", v, 0);
        rd(A_OUT, v);   check("R1 OUT", v, 0);
        rd(A_CNF, v);   check("R1 CNF0", v, 32'h2);
        rd(A_CNF + 31, v); check("R1 CNF31", v, 32'h2);
        check("R1 oe/err", {pin_oe, 31'b0, conflict_err} , 0);

        // R2 set/clear aliases
        wr(A_DIRSET, 32'h8000_0001);
        rd(A_DIR, v);   check("R2 DIRSET", v, 32'h8000_0001);
        rd(A_CNF, v);   check("R2 CNF0 bit0", v & 1, 1);
        rd(A_CNF + 31, v); check("R2 CNF31 bit0", v & 1, 1);
        check("R2 pin_oe", pin_oe, 32'h8000_0001);
        wr(A_DIRCLR, 32'h8000_0001);
        rd(A_DIR, v);   check("R2 DIRCLR", v, 0);
        rd(A_CNF + 31, v); check("R2 CNF31 cleared", v & 1, 0);

        // R3 whole-word write and CNF-side write
        wr(A_DIR, 32'h8000_0001);
        rd(A_CNF, v);   check("R3 CNF0 bit0", v & 1, 1);
        rd(A_CNF + 31, v); check("R3 CNF31 bit0", v & 1, 1);
        wr(A_CNF + 4, 32'h1);
        rd(A_DIR, v);   check("R3 DIR via CNF4", v, 32'h8000_0011);
        wr(A_DIR, 0);
        rd(A_CNF + 4, v); check("R3 CNF4 after DIR=0", v, 0);

        // R4 output aliases
        wr(A_OUTSET, 32'h0000_0300);
        check("R4 OUTSET", pin_out, 32'h0000_0300);
        wr(A_OUTCLR, 32'h0000_0100);
        check("R4 OUTCLR", pin_out, 32'h0000_0200);
        wr(A_OUT, 0);
        check("R4 OUT word", pin_out, 0);

        // R11 IN writes ignored, upper CNF bits read 0
        wr(A_IN, 32'hFFFF_FFFF);
        check("R11 pin_out after IN write", pin_out, 0);
        check("R11 pin_oe after IN write", pin_oe, 0);
        wr(A_CNF + 7, 32'hFFFF_FFFE);
        rd(A_CNF + 7, v); check("R11 CNF7 upper bits", v, 32'hE);
        wr(A_CNF + 7, 32'h2);

        // Vector table on pin TP
        for (int k = 0; k < 11; k++) begin
            logic [7:0] e;
            e = VEC[k];
            @(negedge clk);
            pin_driven[TP] = e[3];
            pin_level[TP]  = e[2];
            wr(e[1] ? A_OUTSET : A_OUTCLR, 32'(1) << TP);
            wr(A_CNF + TP, {28'b0, e[7:4]});
            @(negedge clk);
            if (e[5])            tag = "R8";
            else if (e[4])       tag = "R9";
            else if (e[3])       tag = "R5";
            else if (e[7:6] != 0) tag = "R7";
            else                 tag = "R6";
            rd(A_IN, v);
            check($sformatf("%s vector %0d", tag, k), 32'(v[TP]), 32'(e[0]));
        end
        check("R10 no error after vectors", 32'(conflict_err), 0);

        // R10 conflict detection
        wr(A_CNF + TP, 0);
        wr(A_OUTCLR, 32'(1) << TP);
        @(negedge clk);
        pin_driven[9] = 1; pin_level[9] = 1;
        wr(A_CNF + 9, 0);
        @(negedge clk);
        check("R10 input pin driven", 32'(conflict_err), 0);
        wr(A_CNF + 9, 32'h1);
        @(negedge clk);
        check("R10 conflict raised", 32'(conflict_err), 1);
        pin_driven[9] = 0;
        wr(A_CNF + 9, 0);
        repeat (2) @(negedge clk);
        check("R10 sticky", 32'(conflict_err), 1);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 err cleared by reset", 32'(conflict_err), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule